// File: doc/BRIEF.md
# Full-Bridge Motor Drive Control with Fault Latch

This block is the digital control core of a full-bridge DC motor driver. Two direction inputs set the state of the two half-bridge legs. An enable input and a disable input gate the whole bridge. The block also takes synchronous fault levels from the analog front end: supply undervoltage, overtemperature, a raw short-circuit indication and a chopper-active signal from the current limiter. It produces a two-bit drive code for each leg and an active-low status flag, which the pad ring turns into an open-drain pin.

Faults fall into three classes. Undervoltage clears itself, and it also works as a power-on reset of the stored fault state. Overtemperature and a filtered short circuit are latched. They keep the bridge off until the enable or disable input gives a clearing edge. Current-limit chopping turns the legs off but does not raise the status flag. Enable and disable are asynchronous, so each passes through a synchronizer before its edges are detected.

Top module: `hbridge_ctrl`

## Requirements
- R1: When the bridge is allowed to drive, leg A follows dir_a_i and leg B follows dir_b_i in the same cycle. Each leg code is {drive_enable, level}: 2'b11 drives high and 2'b10 drives low. Equal direction inputs give the low or the high freewheel state.
- R2: A synchronized disable of 1 or a synchronized enable of 0 sets both leg codes to 2'b00 (high impedance), whatever the direction inputs are.
- R3: uv_i at 1 sets both legs to 2'b00 in the same cycle. Nothing is latched, so drive resumes in the cycle uv_i returns to 0.
- R4: A one-cycle pulse on ot_i is stored. The legs stay at 2'b00 until a falling edge of the synchronized disable or a rising edge of the synchronized enable clears the store.
- R5: A single cycle of uv_i clears every stored fault and restarts the short-circuit filter.
- R6: flag_no is 0 while the bridge is disabled, while uv_i is 1, or while a fault is stored. It is 1 otherwise.
- R7: chop_i at 1 sets both legs to 2'b00 while flag_no stays 1.
- R8: sc_i is stored as a fault only at the FILT_CYC-th consecutive clock edge at which it is sampled high. Any low sample restarts the count.
- R9: While rst_ni is low and for the synchronizer latency after it, both legs read 2'b00 and flag_no reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_a_i | input | 1 | Requested level for leg A |
| dir_b_i | input | 1 | Requested level for leg B |
| dis_i | input | 1 | Disable, active high, asynchronous |
| en_i | input | 1 | Enable, active high, asynchronous |
| uv_i | input | 1 | Supply undervoltage level |
| ot_i | input | 1 | Overtemperature level |
| sc_i | input | 1 | Raw short-circuit indication |
| chop_i | input | 1 | Current-limit chopper holding the legs off |
| out_a_o | output | 2 | Leg A code {drive_enable, level} |
| out_b_o | output | 2 | Leg B code {drive_enable, level} |
| flag_no | output | 1 | Status flag, active low |

## Verification
The bench sweeps every combination of enable, disable and the two direction inputs. A design that swapped the legs, or that let either gate input through, fails at once on this sweep. The short-circuit filter is probed on both sides of its threshold and with a one-cycle gap in a long pulse. An off-by-one count, or a counter that does not restart, would latch one cycle early or latch on a broken pulse. The latched fault is cleared by each legal edge and by an undervoltage blip, which exposes a store that ignores the clear or one that clears itself. Chopping is checked for a flag that stays high, which catches a design that folds chopping into the fault flag.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef logic [1:0] hb_drv_t;  // {drive_enable, level}
  localparam hb_drv_t DRV_OFF = 2'b00;
  localparam hb_drv_t DRV_LO  = 2'b10;
  localparam hb_drv_t DRV_HI  = 2'b11;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/hb_fault_latch.sv
module hb_fault_latch #(
  parameter int FILT_CYC = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic uv_i,
  input  logic ot_i,
  input  logic sc_i,
  input  logic clr_i,
  output logic fault_o
);
  localparam int CW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(FILT_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          flt_q;
  logic          sc_hit;

  assign sc_hit = sc_i && (cnt_q == CNT_TOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      flt_q <= 1'b0;
    end else if (uv_i) begin
      // undervoltage is a power-on reset of the fault state
      cnt_q <= '0;
      flt_q <= 1'b0;
    end else begin
      if (!sc_i)               cnt_q <= '0;
      else if (cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
      // a present fault wins over a clear edge
      flt_q <= ot_i | sc_hit | (flt_q & ~clr_i);
    end
  end

  assign fault_o = flt_q;
endmodule

// File: rtl/hb_half_out.sv
module hb_half_out
  import hb_pkg::*;
(
  input  logic    drive_ok_i,
  input  logic    level_i,
  output hb_drv_t drv_o
);
  always_comb begin
    if (!drive_ok_i)  drv_o = DRV_OFF;
    else if (level_i) drv_o = DRV_HI;
    else              drv_o = DRV_LO;
  end
endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl
  import hb_pkg::*;
#(
  parameter int FILT_CYC    = 250,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dir_a_i,
  input  logic       dir_b_i,
  input  logic       dis_i,
  input  logic       en_i,
  input  logic       uv_i,
  input  logic       ot_i,
  input  logic       sc_i,
  input  logic       chop_i,
  output logic [1:0] out_a_o,
  output logic [1:0] out_b_o,
  output logic       flag_no
);
  localparam int NLEG = 2;

  logic en_s, dis_s, en_q, dis_q;
  logic clr_evt, fault, gate_on, drive_ok;
  logic [NLEG-1:0] dir_vec;
  hb_drv_t drv [NLEG];

  hb_sync #(.STAGES(SYNC_STAGES)) u_sync_en (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(en_i), .q_o(en_s));
  hb_sync #(.STAGES(SYNC_STAGES)) u_sync_dis (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(dis_i), .q_o(dis_s));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      dis_q <= 1'b0;
    end else begin
      en_q  <= en_s;
      dis_q <= dis_s;
    end
  end

  assign clr_evt = (en_s & ~en_q) | (dis_q & ~dis_s);

  hb_fault_latch #(.FILT_CYC(FILT_CYC)) u_flt (
    .clk_i(clk_i), .rst_ni(rst_ni), .uv_i(uv_i), .ot_i(ot_i),
    .sc_i(sc_i), .clr_i(clr_evt), .fault_o(fault));

  assign gate_on  = en_s & ~dis_s;
  assign drive_ok = gate_on & ~uv_i & ~fault & ~chop_i;
  assign dir_vec  = {dir_b_i, dir_a_i};

  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    hb_half_out u_leg (
      .drive_ok_i(drive_ok), .level_i(dir_vec[g]), .drv_o(drv[g]));
  end

  assign out_a_o = drv[0];
  assign out_b_o = drv[1];
  // chopping is not a fault: flag ignores chop_i
  assign flag_no = gate_on & ~uv_i & ~fault;
endmodule

// File: rtl/hbridge_ctrl_chk.sv
module hbridge_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_s,
  input logic       dis_s,
  input logic       uv_i,
  input logic       chop_i,
  input logic       fault,
  input logic       clr_evt,
  input logic       dir_a_i,
  input logic       dir_b_i,
  input logic [1:0] out_a_o,
  input logic [1:0] out_b_o,
  input logic       flag_no
);
  a_r1_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_s && !dis_s && !uv_i && !fault && !chop_i) |->
      (out_a_o == {1'b1, dir_a_i}) && (out_b_o == {1'b1, dir_b_i}));

  a_r2_gate_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_s || dis_s) |-> (out_a_o == 2'b00) && (out_b_o == 2'b00) && !flag_no);

  a_r3_uv_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_i |-> (out_a_o == 2'b00) && (out_b_o == 2'b00) && !flag_no);

  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault && !uv_i && !clr_evt) |=> fault);

  a_r5_uv_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_i |=> !fault);

  a_r7_chop_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chop_i && en_s && !dis_s && !uv_i && !fault) |->
      flag_no && (out_a_o == 2'b00) && (out_b_o == 2'b00));

  a_r1_legal_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_a_o != 2'b01) && (out_b_o != 2'b01));
endmodule

bind hbridge_ctrl hbridge_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_s(en_s), .dis_s(dis_s), .uv_i(uv_i),
  .chop_i(chop_i), .fault(fault), .clr_evt(clr_evt), .dir_a_i(dir_a_i),
  .dir_b_i(dir_b_i), .out_a_o(out_a_o), .out_b_o(out_b_o), .flag_no(flag_no));

// File: tb/hbridge_ctrl_tb.sv
`timescale 1ns/1ps
module hbridge_ctrl_tb;
  localparam int FILT = 250;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir_a = 0, dir_b = 0, dis = 0, en = 0, uv = 0, ot = 0, sc = 0, chop = 0;
  logic [1:0] out_a, out_b;
  logic flag_n;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  hbridge_ctrl #(.FILT_CYC(FILT), .SYNC_STAGES(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .dir_a_i(dir_a), .dir_b_i(dir_b),
    .dis_i(dis), .en_i(en), .uv_i(uv), .ot_i(ot), .sc_i(sc), .chop_i(chop),
    .out_a_o(out_a), .out_b_o(out_b), .flag_no(flag_n));

  task automatic wn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [4:0] got, input logic [4:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b (out_a,out_b,flag_n)", req, got, exp);
    end
  endtask

  function automatic logic [4:0] model(input logic ok, input logic fl);
    logic [1:0] a, b;
    a = ok ? {1'b1, dir_a} : 2'b00;
    b = ok ? {1'b1, dir_b} : 2'b00;
    return {a, b, fl};
  endfunction

  function automatic logic [4:0] drv_exp();
    return model(1'b1, 1'b1);
  endfunction

  task automatic run_on();
    en = 1; dis = 0; dir_a = 1; dir_b = 0;
    wn(4);
  endtask

  task automatic latch_ot();
    ot = 1; wn(1); ot = 0;
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wn(3);
    chk("R9 reset", {out_a, out_b, flag_n}, 5'b0000_0);
    rst_n = 1;
    wn(3);
    chk("R9 after reset en low", {out_a, out_b, flag_n}, 5'b0000_0);

    // sweep gate and direction inputs
    for (int v = 0; v < 16; v++) begin
      {en, dis, dir_a, dir_b} = 4'(v);
      wn(4);
      if (en && !dis) chk("R1 R6 drive", {out_a, out_b, flag_n}, drv_exp());
      else            chk("R2 R6 gated", {out_a, out_b, flag_n}, model(1'b0, 1'b0));
    end

    // latched overtemperature, cleared by enable rise
    run_on();
    chk("R1 drive before fault", {out_a, out_b, flag_n}, 5'b1110_1);
    latch_ot();
    chk("R4 latched", {out_a, out_b, flag_n}, 5'b0000_0);
    dir_a = 0; dir_b = 1; wn(3);
    chk("R4 holds after dir change", {out_a, out_b, flag_n}, 5'b0000_0);
    en = 0; wn(4); en = 1; wn(4);
    chk("R4 cleared by enable rise", {out_a, out_b, flag_n}, drv_exp());

    // cleared by disable fall
    latch_ot();
    dis = 1; wn(4);
    chk("R4 R6 still off under disable", {out_a, out_b, flag_n}, 5'b0000_0);
    dis = 0; wn(4);
    chk("R4 cleared by disable fall", {out_a, out_b, flag_n}, drv_exp());

    // undervoltage is self-clearing
    uv = 1; #1;
    chk("R3 uv off", {out_a, out_b, flag_n}, 5'b0000_0);
    wn(3); uv = 0; #1;
    chk("R3 uv release resumes", {out_a, out_b, flag_n}, drv_exp());
    wn(1);

    // undervoltage clears a stored fault
    latch_ot();
    chk("R5 fault stored", {out_a, out_b, flag_n}, 5'b0000_0);
    uv = 1; wn(1); uv = 0; #1;
    chk("R5 uv clears stored fault", {out_a, out_b, flag_n}, drv_exp());
    wn(1);

    // chopping
    chop = 1; #1;
    chk("R7 chop off flag high", {out_a, out_b, flag_n}, 5'b0000_1);
    wn(1); chop = 0; #1;
    chk("R7 chop release", {out_a, out_b, flag_n}, drv_exp());
    wn(1);

    // short-circuit filter: FILT-1 edges does not latch
    sc = 1; wn(FILT - 1); sc = 0; wn(2);
    chk("R8 short pulse ignored", {out_a, out_b, flag_n}, drv_exp());
    // gap restarts the count
    sc = 1; wn(FILT - 1); sc = 0; wn(1); sc = 1; wn(FILT - 1); sc = 0; wn(2);
    chk("R8 gap restarts filter", {out_a, out_b, flag_n}, drv_exp());
    // exact threshold
    sc = 1; wn(FILT - 1);
    chk("R8 one edge before threshold", {out_a, out_b, flag_n}, drv_exp());
    wn(1);
    chk("R8 latched at threshold", {out_a, out_b, flag_n}, 5'b0000_0);
    sc = 0; wn(3);
    chk("R8 short stays latched", {out_a, out_b, flag_n}, 5'b0000_0);
    en = 0; wn(4); en = 1; wn(4);
    chk("R4 R8 short cleared by enable rise", {out_a, out_b, flag_n}, drv_exp());

    // uv restarts the filter count
    sc = 1; wn(FILT - 2); uv = 1; wn(1); uv = 0; wn(2); sc = 0; wn(1);
    chk("R5 uv restarts filter", {out_a, out_b, flag_n}, drv_exp());

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule